// File: doc/BRIEF.md
# Graded Pack Protection Controller

This block decides the protection level of a battery pack from flags that have already been digitized. For every cell it receives a warning-band flag, a hard-limit flag and a severe-fault flag. It also receives one watchdog-trip flag, a service-clear request and a programmable reaction budget. From these it moves between three levels: full operation, a derated band, and a latched disconnect level. In the derated band the block asks for reduced current and alerts the driver and the vehicle controller. In the disconnect level it commands the contactors open.

Degradation is graded. A cell approaching its limit moves the pack into the derated band, and only a limit actually exceeded while already derated opens the contactors. A severe cell fault or a watchdog trip skips the derated band and goes straight to disconnect. Once the contactors are open, the block holds that level until a service clear or a reset. When it enters disconnect, it emits a one-cycle record strobe together with a cause code.

A deadline monitor counts cycles from the first hard-limit, severe or watchdog cycle. If the contactor-open output has not asserted when the programmed budget runs out, the monitor raises a sticky miss flag. This lets the detection and reaction path be held against the fault tolerant time interval.

Top module: `pack_guard`

## Requirements
- R1: After reset the controller is at full operation, and derate_o, alert_o, contactor_open_o, rec_stb_o, rec_cause_o and deadline_miss_o are all 0.
- R2: At full operation, a warning flag on any cell, with no severe or watchdog flag, moves the controller to the derated band at the next clock edge. In the derated band derate_o=1, alert_o=1 and contactor_open_o=0.
- R3: In the derated band, a cycle with no warning, hard-limit, severe or watchdog flag on any cell returns the controller to full operation at the next edge.
- R4: A hard-limit flag is graded. At full operation it moves the controller to the derated band. In the derated band it moves the controller to disconnect, where contactor_open_o=1.
- R5: A severe flag on any cell, or the watchdog flag, moves the controller from any level to disconnect at the next edge, without passing through the derated band.
- R6: Disconnect is latched. It holds while every flag is low and releases to full operation only on svc_clr_i or on reset.
- R7: In disconnect, a hard-limit, severe or watchdog flag in the same cycle as svc_clr_i keeps the controller in disconnect.
- R8: On entry to disconnect, rec_stb_o is high for exactly one cycle, and rec_cause_o is set to 2'b11 for a watchdog trip, 2'b10 for a severe fault, or 2'b01 for an exceeded limit, with that priority. rec_cause_o then holds its value until the next entry.
- R9: derate_o and alert_o are high in both the derated band and disconnect. contactor_open_o is high only in disconnect.
- R10: The deadline counter arms on the first cycle that shows a hard-limit, severe or watchdog flag outside disconnect. If contactor_open_o is still low after budget_i further cycles, deadline_miss_o goes high at the following edge. The flag is sticky until svc_clr_i or reset.
- R11: svc_clr_i has no effect on the level at full operation or in the derated band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| warn_i | input | NCELL | Per-cell warning-band flag |
| limit_i | input | NCELL | Per-cell hard-limit-exceeded flag |
| severe_i | input | NCELL | Per-cell severe-fault flag |
| wdog_i | input | 1 | Controller watchdog trip |
| svc_clr_i | input | 1 | Service clear request |
| budget_i | input | CW | Reaction budget in cycles |
| derate_o | output | 1 | Reduce current / power request |
| alert_o | output | 1 | Driver and vehicle-controller alert |
| contactor_open_o | output | 1 | Open-contactor command |
| rec_stb_o | output | 1 | One-cycle fault-record strobe |
| rec_cause_o | output | 2 | Cause code of the last disconnect entry |
| deadline_miss_o | output | 1 | Reaction budget exceeded (sticky) |

## Verification
The bound checker watches, on every cycle, that the contactor command never appears without derate, that a severe or watchdog flag always produces disconnect at the next edge, that disconnect holds without a clear, that a hard flag outranks a simultaneous clear, and that the record strobe lasts one cycle and coincides with entry to disconnect. The vector table and the directed tests are what show the remaining behaviour. These include the graded two-step path for a hard limit, the return from derate once the flags clear, the cause priority when several sources coincide, the exact edge at which the deadline flag rises for a given budget, and release of the latch by a clear or by reset.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;

    typedef enum logic [1:0] {
        LVL_FULL   = 2'd0,
        LVL_DERATE = 2'd1,
        LVL_OPEN   = 2'd2
    } level_t;

    typedef logic [1:0] cause_t;

    localparam cause_t CAUSE_NONE  = 2'b00;
    localparam cause_t CAUSE_LIMIT = 2'b01;
    localparam cause_t CAUSE_SEVERE = 2'b10;
    localparam cause_t CAUSE_WDOG  = 2'b11;

    typedef struct packed {
        logic warn;
        logic limit;
        logic severe;
        logic wdog;
    } pack_flags_t;

    function automatic cause_t pick_cause(input pack_flags_t f);
        if (f.wdog)        return CAUSE_WDOG;
        else if (f.severe) return CAUSE_SEVERE;
        else               return CAUSE_LIMIT;
    endfunction

    function automatic logic is_hard(input pack_flags_t f);
        return f.limit | f.severe | f.wdog;
    endfunction

endpackage

// File: rtl/pack_guard_merge.sv
module pack_guard_merge #(
    parameter int NCELL = 4
) (
    input  logic [NCELL-1:0]          warn_i,
    input  logic [NCELL-1:0]          limit_i,
    input  logic [NCELL-1:0]          severe_i,
    input  logic                      wdog_i,
    output pack_guard_pkg::pack_flags_t flags_o
);
    logic [NCELL:0] warn_acc;
    logic [NCELL:0] limit_acc;
    logic [NCELL:0] sev_acc;

    assign warn_acc[0]  = 1'b0;
    assign limit_acc[0] = 1'b0;
    assign sev_acc[0]   = 1'b0;

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        assign warn_acc[c+1]  = warn_acc[c]  | warn_i[c];
        assign limit_acc[c+1] = limit_acc[c] | limit_i[c];
        assign sev_acc[c+1]   = sev_acc[c]   | severe_i[c];
    end

    assign flags_o.warn   = warn_acc[NCELL];
    assign flags_o.limit  = limit_acc[NCELL];
    assign flags_o.severe = sev_acc[NCELL];
    assign flags_o.wdog   = wdog_i;
endmodule

// File: rtl/pack_guard_level.sv
module pack_guard_level
    import pack_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pack_flags_t flags_i,
    input  logic        clr_i,
    output level_t      level_o,
    output logic        stb_o,
    output cause_t      cause_o
);
    level_t lvl_q, lvl_d;
    logic   stb_q;
    cause_t cause_q;

    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_FULL: begin
                if (flags_i.severe || flags_i.wdog)     lvl_d = LVL_OPEN;
                else if (flags_i.limit || flags_i.warn) lvl_d = LVL_DERATE;
            end
            LVL_DERATE: begin
                if (is_hard(flags_i))  lvl_d = LVL_OPEN;
                else if (flags_i.warn) lvl_d = LVL_DERATE;
                else                   lvl_d = LVL_FULL;
            end
            LVL_OPEN: begin
                if (clr_i && !is_hard(flags_i)) lvl_d = LVL_FULL;
            end
            default: lvl_d = LVL_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= LVL_FULL;
            stb_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            lvl_q <= lvl_d;
            stb_q <= (lvl_d == LVL_OPEN) && (lvl_q != LVL_OPEN);
            if ((lvl_d == LVL_OPEN) && (lvl_q != LVL_OPEN))
                cause_q <= pick_cause(flags_i);
        end
    end

    assign level_o = lvl_q;
    assign stb_o   = stb_q;
    assign cause_o = cause_q;
endmodule

// File: rtl/pack_guard_deadline.sv
module pack_guard_deadline #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig_i,
    input  logic          opened_i,
    input  logic          clr_i,
    input  logic [CW-1:0] budget_i,
    output logic          miss_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          miss_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            miss_q  <= 1'b0;
        end else if (opened_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!armed_q) begin
            if (trig_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end
        end else begin
            if (cnt_q >= budget_i) miss_q <= 1'b1;
            if (cnt_q != CNT_MAX)  cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign miss_o = miss_q;
endmodule

// File: rtl/pack_guard.sv
module pack_guard
    import pack_guard_pkg::*;
#(
    parameter int NCELL = 4,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCELL-1:0] warn_i,
    input  logic [NCELL-1:0] limit_i,
    input  logic [NCELL-1:0] severe_i,
    input  logic             wdog_i,
    input  logic             svc_clr_i,
    input  logic [CW-1:0]    budget_i,
    output logic             derate_o,
    output logic             alert_o,
    output logic             contactor_open_o,
    output logic             rec_stb_o,
    output logic [1:0]       rec_cause_o,
    output logic             deadline_miss_o
);
    pack_flags_t flags;
    level_t      level;
    cause_t      cause;
    logic        opened;

    pack_guard_merge #(.NCELL(NCELL)) u_merge (
        .warn_i   (warn_i),
        .limit_i  (limit_i),
        .severe_i (severe_i),
        .wdog_i   (wdog_i),
        .flags_o  (flags)
    );

    pack_guard_level u_level (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .clr_i   (svc_clr_i),
        .level_o (level),
        .stb_o   (rec_stb_o),
        .cause_o (cause)
    );

    assign opened = (level == LVL_OPEN);

    pack_guard_deadline #(.CW(CW)) u_deadline (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (is_hard(flags)),
        .opened_i (opened),
        .clr_i    (svc_clr_i),
        .budget_i (budget_i),
        .miss_o   (deadline_miss_o)
    );

    assign derate_o         = (level != LVL_FULL);
    assign alert_o          = (level != LVL_FULL);
    assign contactor_open_o = opened;
    assign rec_cause_o      = cause;
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk #(
    parameter int NCELL = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NCELL-1:0] warn_i,
    input logic [NCELL-1:0] limit_i,
    input logic [NCELL-1:0] severe_i,
    input logic             wdog_i,
    input logic             svc_clr_i,
    input logic             derate_o,
    input logic             contactor_open_o,
    input logic             rec_stb_o
);
    p_open_needs_derate_r9: assert property (@(posedge clk) disable iff (rst)
        contactor_open_o |-> derate_o);

    p_severe_direct_r5: assert property (@(posedge clk) disable iff (rst)
        ((|severe_i) || wdog_i) |=> contactor_open_o);

    p_latched_r6: assert property (@(posedge clk) disable iff (rst)
        (contactor_open_o && !svc_clr_i) |=> contactor_open_o);

    p_hard_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (contactor_open_o && svc_clr_i && ((|limit_i) || (|severe_i) || wdog_i))
        |=> contactor_open_o);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        rec_stb_o |=> !rec_stb_o);

    p_strobe_on_entry_r8: assert property (@(posedge clk) disable iff (rst)
        rec_stb_o |-> (contactor_open_o && !$past(contactor_open_o)));

    p_warn_derates_r2: assert property (@(posedge clk) disable iff (rst)
        (!derate_o && (|warn_i)) |=> derate_o);
endmodule

bind pack_guard pack_guard_chk #(.NCELL(NCELL)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .warn_i           (warn_i),
    .limit_i          (limit_i),
    .severe_i         (severe_i),
    .wdog_i           (wdog_i),
    .svc_clr_i        (svc_clr_i),
    .derate_o         (derate_o),
    .contactor_open_o (contactor_open_o),
    .rec_stb_o        (rec_stb_o)
);

// File: tb/test_pack_guard.sv
`timescale 1ns/1ps
module test_pack_guard;
    localparam int NCELL = 4;
    localparam int CW    = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [NCELL-1:0] warn_i, limit_i, severe_i;
    logic             wdog_i, svc_clr_i;
    logic [CW-1:0]    budget_i;
    logic             derate_o, alert_o, contactor_open_o, rec_stb_o, deadline_miss_o;
    logic [1:0]       rec_cause_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pack_guard #(.NCELL(NCELL), .CW(CW)) i_pack_guard (
        .clk(clk), .rst(rst), .warn_i(warn_i), .limit_i(limit_i),
        .severe_i(severe_i), .wdog_i(wdog_i), .svc_clr_i(svc_clr_i),
        .budget_i(budget_i), .derate_o(derate_o), .alert_o(alert_o),
        .contactor_open_o(contactor_open_o), .rec_stb_o(rec_stb_o),
        .rec_cause_o(rec_cause_o), .deadline_miss_o(deadline_miss_o)
    );

    // fields: [12] warn [11] limit [10] severe [9] wdog [8] clr [7:6] cell
    //         [5] exp derate/alert [4] exp open [3] exp strobe [2] check cause [1:0] cause
    localparam int NV = 19;
    localparam logic [12:0] VEC [0:NV-1] = '{
        13'b00000_00_000_0_00, // idle at full operation (R1)
        13'b10000_01_100_0_00, // warn cell1 -> derate (R2)
        13'b10001_01_100_0_00, // clear while derated, warn held (R11)
        13'b00000_00_000_0_00, // flags gone -> full (R3)
        13'b10000_10_100_0_00, // warn cell2 (R2)
        13'b01000_11_111_1_01, // limit while derated -> open, cause 01 (R4 R8)
        13'b00000_00_110_0_00, // latched (R6)
        13'b01001_00_110_0_00, // clear with limit -> stays open (R7)
        13'b00001_00_000_0_00, // clear -> full (R6)
        13'b00100_10_111_1_10, // severe from full -> open, cause 10 (R5 R8)
        13'b00001_00_000_0_00, // clear (R6)
        13'b10000_00_100_0_00, // warn -> derate (R2)
        13'b00110_00_111_1_11, // wdog + severe -> open, cause 11 (R5 R8)
        13'b00001_00_000_0_00, // clear (R6)
        13'b01000_01_100_0_00, // limit from full -> derate only (R4)
        13'b01000_01_111_1_01, // limit again -> open (R4)
        13'b00001_00_000_0_00, // clear (R6)
        13'b00001_00_000_0_00, // clear at full has no effect (R11)
        13'b00000_00_000_0_00  // idle (R9)
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        warn_i = '0; limit_i = '0; severe_i = '0; wdog_i = 1'b0; svc_clr_i = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; idle_inputs();
        step(); step();
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog timeout");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; idle_inputs(); budget_i = 16'd8;
        do_reset();
        #1;
        check({2'b0, derate_o, alert_o, contactor_open_o, rec_stb_o, deadline_miss_o, 1'b0},
              8'h00, "R1 reset outputs");
        check({6'b0, rec_cause_o}, 8'h00, "R1 reset cause");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            warn_i = '0; limit_i = '0; severe_i = '0;
            warn_i[VEC[i][7:6]]   = VEC[i][12];
            limit_i[VEC[i][7:6]]  = VEC[i][11];
            severe_i[VEC[i][7:6]] = VEC[i][10];
            wdog_i    = VEC[i][9];
            svc_clr_i = VEC[i][8];
            step();
            check({7'b0, derate_o}, {7'b0, VEC[i][5]}, $sformatf("R9 derate row %0d", i));
            check({7'b0, alert_o}, {7'b0, VEC[i][5]}, $sformatf("R2 alert row %0d", i));
            check({7'b0, contactor_open_o}, {7'b0, VEC[i][4]}, $sformatf("R6 open row %0d", i));
            check({7'b0, rec_stb_o}, {7'b0, VEC[i][3]}, $sformatf("R8 strobe row %0d", i));
            if (VEC[i][2])
                check({6'b0, rec_cause_o}, {6'b0, VEC[i][1:0]}, $sformatf("R8 cause row %0d", i));
        end

        // R10: one-cycle limit pulse, warn held, no disconnect -> miss after budget
        do_reset();
        budget_i = 16'd4;
        @(negedge clk); warn_i = 4'b0001; limit_i = 4'b0001;
        step();
        @(negedge clk); limit_i = '0;
        for (int k = 1; k <= 4; k++) step();
        check({7'b0, deadline_miss_o}, 8'h00, "R10 no miss before budget");
        check({7'b0, contactor_open_o}, 8'h00, "R10 still not open");
        step();
        check({7'b0, deadline_miss_o}, 8'h01, "R10 miss at budget");
        step();
        check({7'b0, deadline_miss_o}, 8'h01, "R10 miss sticky");
        @(negedge clk); svc_clr_i = 1'b1;
        step();
        check({7'b0, deadline_miss_o}, 8'h00, "R10 miss cleared");
        check({7'b0, derate_o}, 8'h01, "R11 clear keeps derate");

        // R10: limit held, disconnect within budget -> no miss
        do_reset();
        budget_i = 16'd1;
        @(negedge clk); limit_i = 4'b1000;
        step(); step();
        check({7'b0, contactor_open_o}, 8'h01, "R4 open via derate");
        @(negedge clk); limit_i = '0;
        for (int k = 0; k < 5; k++) step();
        check({7'b0, deadline_miss_o}, 8'h00, "R10 no miss when opened in time");

        // R6: reset releases disconnect
        @(negedge clk); severe_i = 4'b0100;
        step();
        check({7'b0, contactor_open_o}, 8'h01, "R5 severe open");
        do_reset();
        #1;
        check({7'b0, contactor_open_o}, 8'h00, "R6 reset releases");
        check({7'b0, derate_o}, 8'h00, "R1 derate after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule